// File: doc/BRIEF.md
# Multi-Lane Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter. It has no multipliers. The coefficients are given as a parameter. At elaboration the block folds them into a table of partial sums, one entry for every combination of tap bits. Each processing cycle reads that table once per lane. The current bit of every stored tap sample together forms the table address.

The sample word is divided into `LANES` equal bit groups, and all lanes of a group are read in the same cycle. One result therefore takes `DATA_W / LANES` cycles. Setting `LANES = 1` gives the smallest, purely bit-serial form. Setting `LANES = DATA_W` finishes in a single cycle at the cost of one table read per bit. A lane count that does not divide `DATA_W` stops elaboration with an error.

The accumulator starts with the most significant bit group and shifts left by `LANES` bits per step. The table read for the sample's top bit is subtracted, so the tap samples are treated as two's complement. Samples arrive over a valid/ready handshake. The filter takes one sample only while idle, then signals the result with a one-cycle valid pulse.

Top module: `mbs_da_fir`

## Requirements
- R1: After a sample is accepted on a rising edge, `out_valid` is high for exactly one cycle, and that cycle is exactly `DATA_W/LANES` cycles after the accepting edge (16, 8, 4, 2, 1 cycles for LANES 1, 2, 4, 8, 16 at the default width).
- R2: `in_ready` is low from the accepting edge until the cycle in which `out_valid` is high, and `in_ready` is high in that cycle and afterwards while idle.
- R3: `in_valid` asserted while `in_ready` is low is ignored: the delay line does not shift, and the result still in flight is unchanged.
- R4: `out_data` equals the sum over taps i = 0..TAPS-1 of c_i * x[n-i]. Here x[n] is the newest accepted sample (tap 0), and c_i is the signed field `COEFS[i*COEF_W +: COEF_W]`.
- R5: Both samples and coefficients are two's complement. Negative values, including the most negative sample -2^(DATA_W-1), give exact results.
- R6: `out_data` is `DATA_W + COEF_W + clog2(TAPS)` bits wide and holds the exact sum without overflow, even when every tap carries the extreme sample value.
- R7: A synchronous reset empties the delay line (all taps zero), clears the accumulator and stops processing. The cycle after reset shows `out_valid` low, `in_ready` high and `out_data` zero.
- R8: Every lane count that divides `DATA_W` gives bit-identical results for the same sample stream.
- R9: `out_data` keeps the last result while the filter is idle, until the next accepted sample begins processing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter idle, sample will be taken |
| in_data | input | DATA_W | Two's-complement sample |
| out_valid | output | 1 | One-cycle pulse marking a finished result |
| out_data | output | DATA_W+COEF_W+clog2(TAPS) | Full-precision signed result |

## Verification
The bound checker watches the handshake and the timing on every cycle. It checks that each result appears exactly `DATA_W/LANES` cycles after its sample was accepted, that the valid pulse lasts one cycle, that `in_ready` stays low while a result is in flight, that the reset state is correct, and that the output is stable while the filter is idle. The arithmetic itself can only be checked by the bench scenarios. These cover the exact sums for impulse, extreme-value and random streams, the sign-bit subtraction, the agreement between all five legal lane counts, and the proof that a sample offered while the filter is busy leaves no trace.

// File: rtl/mbs_fir_pkg.sv
package mbs_fir_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } fir_phase_t;

    // Width of a signed sum of `terms` values each `w` bits wide.
    function automatic int sum_width(input int w, input int terms);
        return w + ((terms > 1) ? $clog2(terms) : 0);
    endfunction

    // Counter width able to index `n` states (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mbs_tap_line.sv
module mbs_tap_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic [DATA_W-1:0]            din,
    output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);

    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] line;
    } tap_state_t;

    tap_state_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_en) begin
            line_d.line[0] = din;
            for (int i = 1; i < TAPS; i++) begin
                line_d.line[i] = line_q.line[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign taps_o = line_q.line;

endmodule

// File: rtl/mbs_lane_lut.sv
module mbs_lane_lut #(
    parameter int                       TAPS   = 4,
    parameter int                       COEF_W = 12,
    parameter int                       SUM_W  = 14,
    parameter logic [TAPS*COEF_W-1:0]   COEFS  = '0
) (
    input  logic [TAPS-1:0]          addr,
    output logic signed [SUM_W-1:0]  psum
);

    localparam int ENTRIES = 1 << TAPS;

    // Sum of the coefficients whose tap bit is set in index k.
    function automatic logic signed [SUM_W-1:0] entry_value(input int k);
        logic signed [SUM_W-1:0] acc;
        logic [COEF_W-1:0]       c;
        acc = '0;
        for (int i = 0; i < TAPS; i++) begin
            c = COEFS[i*COEF_W +: COEF_W];
            if (((k >> i) & 1) != 0) begin
                acc = acc + {{(SUM_W-COEF_W){c[COEF_W-1]}}, c};
            end
        end
        return acc;
    endfunction

    logic signed [SUM_W-1:0] table_w [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        localparam logic signed [SUM_W-1:0] ENTRY = entry_value(k);
        assign table_w[k] = ENTRY;
    end

    assign psum = table_w[addr];

endmodule

// File: rtl/mbs_lane_combine.sv
module mbs_lane_combine #(
    parameter int                       DATA_W = 16,
    parameter int                       TAPS   = 4,
    parameter int                       COEF_W = 12,
    parameter int                       LANES  = 2,
    parameter int                       SUM_W  = 14,
    parameter int                       ACC_W  = 30,
    parameter int                       GRP_W  = 3,
    parameter logic [TAPS*COEF_W-1:0]   COEFS  = '0
) (
    input  logic [TAPS-1:0][DATA_W-1:0] taps,
    input  logic [GRP_W-1:0]            group,
    output logic signed [ACC_W-1:0]     comb
);

    localparam int GROUPS = DATA_W / LANES;
    localparam int IDX_W  = mbs_fir_pkg::idx_width(DATA_W);

    logic [LANES-1:0][SUM_W-1:0] psum_all;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0]        bit_idx;
        logic [TAPS-1:0]         lane_addr;
        logic signed [SUM_W-1:0] lane_sum;

        always_comb begin
            bit_idx = IDX_W'(int'(group) * LANES + j);
            for (int i = 0; i < TAPS; i++) begin
                lane_addr[i] = taps[i][bit_idx];
            end
        end

        mbs_lane_lut #(
            .TAPS   (TAPS),
            .COEF_W (COEF_W),
            .SUM_W  (SUM_W),
            .COEFS  (COEFS)
        ) u_lut (
            .addr (lane_addr),
            .psum (lane_sum)
        );

        assign psum_all[j] = lane_sum;
    end

    // Weight lane j by 2^j; the sample's top bit carries negative weight.
    always_comb begin
        logic signed [ACC_W-1:0] term;
        comb = '0;
        for (int j = 0; j < LANES; j++) begin
            term = {{(ACC_W-SUM_W){psum_all[j][SUM_W-1]}}, psum_all[j]};
            term = term <<< j;
            if ((group == GRP_W'(GROUPS-1)) && (j == LANES-1)) begin
                comb = comb - term;
            end else begin
                comb = comb + term;
            end
        end
    end

endmodule

// File: rtl/mbs_da_fir.sv
module mbs_da_fir #(
    parameter int                       DATA_W = 16,
    parameter int                       COEF_W = 12,
    parameter int                       TAPS   = 4,
    parameter int                       LANES  = 2,
    parameter logic [TAPS*COEF_W-1:0]   COEFS  = 48'h800_7FF_B50_12C
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic                                               in_valid,
    output logic                                               in_ready,
    input  logic [DATA_W-1:0]                                  in_data,
    output logic                                               out_valid,
    output logic [DATA_W+COEF_W+mbs_fir_pkg::idx_width(TAPS)-1:0] out_data
);

    import mbs_fir_pkg::*;

    localparam int GROUPS = DATA_W / LANES;
    localparam int GRP_W  = idx_width(GROUPS);
    localparam int SUM_W  = sum_width(COEF_W, TAPS);
    localparam int ACC_W  = DATA_W + COEF_W + idx_width(TAPS);

    if ((LANES < 1) || (LANES > DATA_W) || ((DATA_W % LANES) != 0)) begin : g_bad_lanes
        $error("mbs_da_fir: LANES must divide DATA_W exactly");
    end

    typedef struct packed {
        fir_phase_t              phase;
        logic [GRP_W-1:0]        step;
        logic signed [ACC_W-1:0] acc;
        logic                    vld;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic                        accept;
    logic [TAPS-1:0][DATA_W-1:0] taps;
    logic [GRP_W-1:0]            group;
    logic signed [ACC_W-1:0]     comb;

    assign accept = in_valid && (st_q.phase == PH_IDLE);
    // Most significant bit group first.
    assign group  = GRP_W'(GROUPS-1) - st_q.step;

    mbs_tap_line #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_taps (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .din      (in_data),
        .taps_o   (taps)
    );

    mbs_lane_combine #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .LANES  (LANES),
        .SUM_W  (SUM_W),
        .ACC_W  (ACC_W),
        .GRP_W  (GRP_W),
        .COEFS  (COEFS)
    ) u_comb (
        .taps  (taps),
        .group (group),
        .comb  (comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.phase == PH_RUN) begin
            st_d.acc = ((st_q.step == '0) ? '0 : (st_q.acc <<< LANES)) + comb;
            if (st_q.step == GRP_W'(GROUPS-1)) begin
                st_d.phase = PH_IDLE;
                st_d.step  = '0;
                st_d.vld   = 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end else if (accept) begin
            st_d.phase = PH_RUN;
            st_d.step  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.phase == PH_IDLE);
    assign out_valid = st_q.vld;
    assign out_data  = st_q.acc;

endmodule

// File: rtl/mbs_fir_checker.sv
module mbs_fir_checker #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int ACC_W  = 30
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);

    localparam int GROUPS = DATA_W / LANES;

    logic pend_q;
    int   age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            age_q  <= 0;
        end else if (in_valid && in_ready) begin
            pend_q <= 1'b1;
            age_q  <= 0;
        end else if (pend_q) begin
            age_q <= age_q + 1;
            if (out_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R1: result appears exactly GROUPS cycles after acceptance
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend_q && (age_q == GROUPS)));

    // R1: valid is a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2: no acceptance while a result is in flight
    a_r2_busy_stall: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !out_valid) |-> !in_ready);

    // R2: ready returns together with the result
    a_r2_ready_on_done: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R2: acceptance drops ready on the next cycle
    a_r2_accept_blocks: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7: reset state
    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready && (out_data == '0)));

    // R9: idle output is held
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(in_ready) && in_ready) |-> $stable(out_data));

endmodule

bind mbs_da_fir mbs_fir_checker #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/mbs_da_fir_test.sv
module mbs_da_fir_test;

    localparam int DW   = 16;
    localparam int CW   = 12;
    localparam int NT   = 4;
    localparam int OW   = DW + CW + 2;
    localparam int NCFG = 5;
    localparam logic [NT*CW-1:0] CSET = 48'h800_7FF_B50_12C;

    int coef [NT] = '{300, -1200, 2047, -2048};

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [DW-1:0] in_data;
    logic rdy [NCFG];
    logic ov  [NCFG];
    logic [OW-1:0] od [NCFG];

    int total = 0;
    int bad   = 0;
    int hist [NT];
    logic [OW-1:0] expv;

    always #5 clk = ~clk;

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        mbs_da_fir #(
            .DATA_W (DW),
            .COEF_W (CW),
            .TAPS   (NT),
            .LANES  (1 << gi),
            .COEFS  (CSET)
        ) uut (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (rdy[gi]),
            .in_data   (in_data),
            .out_valid (ov[gi]),
            .out_data  (od[gi])
        );
    end

    task automatic chk(input string tag, input int cfg, input bit ok,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s lanes=%0d act=%0d exp=%0d", tag, 1 << cfg, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] ref_out();
        longint s = 0;
        for (int i = 0; i < NT; i++) s += longint'(coef[i]) * longint'(hist[i]);
        return s[OW-1:0];
    endfunction

    function automatic bit all_ready();
        for (int g = 0; g < NCFG; g++) if (rdy[g] !== 1'b1) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NT; i++) hist[i] = 0;
        for (int g = 0; g < NCFG; g++) begin
            chk("R7 valid", g, ov[g] == 1'b0, longint'(ov[g]), 0);
            chk("R7 ready", g, rdy[g] == 1'b1, longint'(rdy[g]), 1);
            chk("R7 data", g, od[g] == '0, longint'(od[g]), 0);
        end
    endtask

    // poke: keep in_valid high one more cycle with other data while busy (R3)
    task automatic send(input logic [DW-1:0] x, input bit poke, input string vtag);
        while (!all_ready()) @(negedge clk);
        in_data  = x;
        in_valid = 1'b1;
        @(negedge clk);
        if (poke) in_data = ~x;
        else in_valid = 1'b0;
        for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'($signed(x));
        expv = ref_out();
        for (int m = 0; m <= DW; m++) begin
            if (m > 0) @(negedge clk);
            if (m == 1) in_valid = 1'b0;
            for (int g = 0; g < NCFG; g++) begin
                int c = DW >> g;
                chk("R1 pulse", g, ov[g] == (m == c), longint'(ov[g]), longint'(m == c));
                chk("R2 ready", g, rdy[g] == (m >= c), longint'(rdy[g]), longint'(m >= c));
                if (m == c) begin
                    chk(vtag, g, od[g] == expv,
                        longint'($signed(od[g])), longint'($signed(expv)));
                end
            end
        end
        for (int g = 0; g < NCFG; g++) begin
            chk("R9 hold", g, od[g] == expv, longint'($signed(od[g])), longint'($signed(expv)));
            chk("R8 match", g, od[g] == od[0], longint'($signed(od[g])), longint'($signed(od[0])));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        for (int i = 0; i < NT; i++) hist[i] = 0;
        do_reset();

        // Impulse walks through every coefficient (R4)
        send(16'd1, 1'b0, "R4 impulse");
        for (int k = 0; k < NT; k++) send(16'd0, 1'b0, "R4 impulse");
        send(16'd1000, 1'b0, "R4 small");
        send(16'hFC18, 1'b0, "R5 neg");

        // Extreme values fill every tap (R5, R6)
        for (int k = 0; k < NT; k++) send(16'h8000, 1'b0, "R6 min fill");
        for (int k = 0; k < NT; k++) send(16'h7FFF, 1'b0, "R6 max fill");
        send(16'h8000, 1'b0, "R5 min");
        send(16'hFFFF, 1'b0, "R5 minus one");

        // Busy-time offer is dropped (R3)
        send(16'd1234, 1'b1, "R3 ignore");
        send(16'd0, 1'b0, "R3 no shift");
        send(16'h8001, 1'b1, "R3 ignore");

        // Reset clears history (R7)
        do_reset();
        send(16'd7, 1'b0, "R7 cleared");

        // Random stream
        for (int k = 0; k < 150; k++) begin
            logic [DW-1:0] r = DW'($urandom());
            send(r, ($urandom() % 5) == 0, "R4 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule